// File: doc/BRIEF.md
# Leaky Risk-Score Alert Classifier

This block turns a handful of one-bit warning flags, one per monitored water-quality condition, into a three-level alert. It does not react to any single reading. It keeps an integer risk score instead. On each update tick the score goes up by one if any flag is raised, and down by one if every flag is clear. The score stops at zero and at a configurable ceiling. A momentary glitch therefore barely moves it, while a fault that persists climbs steadily through the tiers.

Two configurable thresholds cut the score into three disjoint bands: Safe, Caution and Unsafe. Each band lights exactly one of the green, yellow and red indicator drives, and the buzzer sounds with red. Each flag is resynchronised through a two-flop chain before use. A free-running divider produces the update tick, so the rise and fall rate can be tuned against the sensor noise. A divider of one takes a variant with no counter and updates on every clock.

Top module: `risk_alert_top`

## Requirements
- R1: Every bit of `warn_i` passes through two flip-flops before it can affect the score. A flag driven just before clock edge k can first change the score at edge k+2.
- R2: On an update tick where at least one synchronised flag is 1 and the score is below `SCORE_MAX`, the score increases by exactly one.
- R3: The score never goes above `SCORE_MAX` and never wraps below zero. It holds at `SCORE_MAX` while flags stay raised and holds at 0 while all flags stay clear.
- R4: On an update tick where all synchronised flags are 0 and the score is above zero, the score decreases by exactly one.
- R5: The score changes only on update ticks. A tick occurs every `TICK_DIV` clocks, first on the `TICK_DIV`-th clock after reset. With `TICK_DIV` = 1 there is a tick on every clock.
- R6: The block shows Safe when the score is below `CAUTION_TH`, Caution from `CAUTION_TH` up to `UNSAFE_TH`-1, and Unsafe from `UNSAFE_TH` upward. Elaboration requires 2 <= `CAUTION_TH` < `UNSAFE_TH` <= `SCORE_MAX`.
- R7: Safe drives only `led_green_o`, Caution drives only `led_yellow_o`, and Unsafe drives `led_red_o`. Exactly one LED is 1 at any time, and `buzzer_o` equals `led_red_o`.
- R8: Any single flag, including the one wired to the critical condition, that stays at 1 brings the block to Unsafe within `UNSAFE_TH` ticks plus the synchroniser delay. The block then stays in Unsafe while that flag is held, whatever the other flags do.
- R9: Starting from score zero, a flag that is raised for a single clock cycle leaves the block in Safe.
- R10: A synchronous reset (`rst` high at a clock edge) clears the score, the synchronisers and the tick divider, so the next output is Safe (green only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| warn_i | input | N_FLAGS | Asynchronous warning flags, 1 = condition abnormal |
| led_green_o | output | 1 | Safe indicator |
| led_yellow_o | output | 1 | Caution indicator |
| led_red_o | output | 1 | Unsafe indicator |
| buzzer_o | output | 1 | Audible alarm enable, active with red |

## Verification
Two situations are hard to reach from the ports. The score has no output of its own, and a wrap at either end only shows up as a wrong tier long after it happens. The stimulus therefore holds a flag long enough to pin the score at the ceiling and then releases it. It checks that red survives exactly as many ticks as the distance between the ceiling and the Unsafe threshold. A long idle stretch then shows that the floor does not wrap. A behavioural model with its own synchroniser delay and tick count is compared on every clock. This comparison covers the randomised phases, including one where the critical flag is held while the others toggle, and a reset issued in the middle of the run.

// File: rtl/risk_alert_pkg.sv
package risk_alert_pkg;

   typedef enum logic [1:0] {
      TIER_SAFE    = 2'd0,
      TIER_CAUTION = 2'd1,
      TIER_UNSAFE  = 2'd2
   } tier_e;

   typedef struct packed {
      logic green;
      logic yellow;
      logic red;
      logic buzz;
   } alert_drv_t;

   function automatic alert_drv_t tier_to_drive(input tier_e t);
      alert_drv_t d;
      d = '0;
      case (t)
         TIER_SAFE:    d.green  = 1'b1;
         TIER_CAUTION: d.yellow = 1'b1;
         default: begin
            d.red  = 1'b1;
            d.buzz = 1'b1;
         end
      endcase
      return d;
   endfunction

endpackage

// File: rtl/warn_sync.sv
module warn_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("warn_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
         if (rst) chain_q <= '0;
         else     chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/update_tick.sv
module update_tick #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);

   if (DIV < 1) begin : g_bad_div
      $error("update_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every_clock
      assign tick_o = 1'b1;
   end else begin : g_divider
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst)               cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                   cnt_q <= cnt_q + CW'(1);
      end
      assign tick_o = (cnt_q == LAST);
   end

endmodule

// File: rtl/score_integrator.sv
module score_integrator #(
   parameter int SCORE_MAX = 15,
   localparam int SW = $clog2(SCORE_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick_i,
   input  logic          any_i,
   output logic [SW-1:0] score_o
);

   localparam logic [SW-1:0] TOP = SW'(SCORE_MAX);

   logic [SW-1:0] score_q;
   logic [SW-1:0] score_d;

   always_comb begin
      score_d = score_q;
      if (tick_i) begin
         if (any_i) begin
            if (score_q != TOP) score_d = score_q + SW'(1);
         end else begin
            if (score_q != '0)  score_d = score_q - SW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) score_q <= '0;
      else     score_q <= score_d;
   end

   assign score_o = score_q;

endmodule

// File: rtl/tier_decode.sv
module tier_decode
   import risk_alert_pkg::*;
#(
   parameter int SW         = 4,
   parameter int CAUTION_TH = 4,
   parameter int UNSAFE_TH  = 10
) (
   input  logic [SW-1:0] score_i,
   output tier_e         tier_o,
   output alert_drv_t    drive_o
);

   localparam logic [SW-1:0] CAU_V = SW'(CAUTION_TH);
   localparam logic [SW-1:0] UNS_V = SW'(UNSAFE_TH);

   always_comb begin
      if (score_i >= UNS_V)      tier_o = TIER_UNSAFE;
      else if (score_i >= CAU_V) tier_o = TIER_CAUTION;
      else                       tier_o = TIER_SAFE;
      drive_o = tier_to_drive(tier_o);
   end

endmodule

// File: rtl/risk_alert_top.sv
module risk_alert_top
   import risk_alert_pkg::*;
#(
   parameter int N_FLAGS     = 3,
   parameter int SCORE_MAX   = 15,
   parameter int CAUTION_TH  = 4,
   parameter int UNSAFE_TH   = 10,
   parameter int TICK_DIV    = 1000,
   parameter int SYNC_STAGES = 2,
   localparam int SCORE_W = $clog2(SCORE_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_FLAGS-1:0] warn_i,
   output logic               led_green_o,
   output logic               led_yellow_o,
   output logic               led_red_o,
   output logic               buzzer_o
);

   if (N_FLAGS < 1) begin : g_bad_flags
      $error("risk_alert_top: N_FLAGS must be at least 1");
   end
   if (CAUTION_TH < 2) begin : g_bad_caution
      $error("risk_alert_top: CAUTION_TH must be at least 2 so one pulse stays Safe");
   end
   if (UNSAFE_TH <= CAUTION_TH) begin : g_bad_order
      $error("risk_alert_top: UNSAFE_TH must exceed CAUTION_TH");
   end
   if (UNSAFE_TH > SCORE_MAX) begin : g_bad_ceiling
      $error("risk_alert_top: UNSAFE_TH must not exceed SCORE_MAX");
   end

   logic [N_FLAGS-1:0] flags_w;
   logic               any_w;
   logic               tick_w;
   logic [SCORE_W-1:0] score_w;
   tier_e              tier_w;
   alert_drv_t         drive_w;

   warn_sync #(
      .WIDTH (N_FLAGS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst    (rst),
      .async_i(warn_i),
      .sync_o (flags_w)
   );

   assign any_w = |flags_w;

   update_tick #(
      .DIV(TICK_DIV)
   ) u_tick (
      .clk   (clk),
      .rst   (rst),
      .tick_o(tick_w)
   );

   score_integrator #(
      .SCORE_MAX(SCORE_MAX)
   ) u_score (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick_w),
      .any_i  (any_w),
      .score_o(score_w)
   );

   tier_decode #(
      .SW        (SCORE_W),
      .CAUTION_TH(CAUTION_TH),
      .UNSAFE_TH (UNSAFE_TH)
   ) u_tier (
      .score_i(score_w),
      .tier_o (tier_w),
      .drive_o(drive_w)
   );

   assign led_green_o  = drive_w.green;
   assign led_yellow_o = drive_w.yellow;
   assign led_red_o    = drive_w.red;
   assign buzzer_o     = drive_w.buzz;

endmodule

module risk_alert_checker #(
   parameter int SW         = 4,
   parameter int SCORE_MAX  = 15,
   parameter int CAUTION_TH = 4,
   parameter int UNSAFE_TH  = 10
) (
   input logic          clk,
   input logic          rst,
   input logic          tick,
   input logic          any,
   input logic [SW-1:0] score,
   input logic          led_g,
   input logic          led_y,
   input logic          led_r,
   input logic          buzz
);

   localparam logic [SW-1:0] TOP   = SW'(SCORE_MAX);
   localparam logic [SW-1:0] CAU_V = SW'(CAUTION_TH);
   localparam logic [SW-1:0] UNS_V = SW'(UNSAFE_TH);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      score <= TOP);

   p_rise_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(tick) && $past(any) && $past(score) != TOP)
      |-> score == $past(score) + SW'(1));

   p_fall_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(tick) && !$past(any) && $past(score) != '0)
      |-> score == $past(score) - SW'(1));

   p_sat_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (($past(score) == TOP && $past(any)) ||
                       ($past(score) == '0 && !$past(any))))
      |-> $stable(score));

   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(tick)) |-> $stable(score));

   p_leds_onehot_r7: assert property (@(posedge clk) disable iff (rst)
      $countones({led_g, led_y, led_r}) == 1);

   p_buzz_red_r7: assert property (@(posedge clk) disable iff (rst)
      buzz == led_r);

   p_tier_r6: assert property (@(posedge clk) disable iff (rst)
      (led_g == (score < CAU_V)) && (led_r == (score >= UNS_V)));

   p_reset_r10: assert property (@(posedge clk)
      rst |=> (score == '0 && led_g));

endmodule

bind risk_alert_top risk_alert_checker #(
   .SW        (SCORE_W),
   .SCORE_MAX (SCORE_MAX),
   .CAUTION_TH(CAUTION_TH),
   .UNSAFE_TH (UNSAFE_TH)
) u_chk (
   .clk  (clk),
   .rst  (rst),
   .tick (tick_w),
   .any  (any_w),
   .score(score_w),
   .led_g(led_green_o),
   .led_y(led_yellow_o),
   .led_r(led_red_o),
   .buzz (buzzer_o)
);

// File: tb/risk_alert_top_bench.sv
module risk_alert_top_bench;

   localparam int NF   = 3;
   localparam int SMAX = 15;
   localparam int CTH  = 4;
   localparam int UTH  = 10;
   localparam int DIV  = 3;
   localparam int CRIT = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NF-1:0] warn = '0;
   logic          g, y, r, bz;

   int checks   = 0;
   int failures = 0;
   bit cmp_on   = 1'b0;

   always #2 clk = ~clk;

   risk_alert_top #(
      .N_FLAGS   (NF),
      .SCORE_MAX (SMAX),
      .CAUTION_TH(CTH),
      .UNSAFE_TH (UTH),
      .TICK_DIV  (DIV)
   ) u_risk_alert_top (
      .clk         (clk),
      .rst         (rst),
      .warn_i      (warn),
      .led_green_o (g),
      .led_yellow_o(y),
      .led_red_o   (r),
      .buzzer_o    (bz)
   );

   // behavioural reference: integer score, two-deep flag delay, tick count
   int m_score = 0;
   int m_cnt   = 0;
   int m_dly[2] = '{0, 0};

   always @(posedge clk) begin
      if (rst) begin
         m_score = 0;
         m_cnt   = 0;
         m_dly   = '{0, 0};
      end else begin
         if (m_cnt == DIV - 1) begin
            if (m_dly[1] != 0) m_score = (m_score < SMAX) ? m_score + 1 : SMAX;
            else               m_score = (m_score > 0) ? m_score - 1 : 0;
            m_cnt = 0;
         end else begin
            m_cnt = m_cnt + 1;
         end
         m_dly[1] = m_dly[0];
         m_dly[0] = int'(warn);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int led_code();
      return {28'd0, g, y, r, bz};
   endfunction

   function automatic int model_code();
      if (m_score < CTH)      return 4'b1000;
      else if (m_score < UTH) return 4'b0100;
      else                    return 4'b0011;
   endfunction

   // R6 R7: per-clock comparison against the model
   always @(negedge clk) begin
      if (cmp_on && !rst)
         chk(led_code() == model_code(), "R6 R7 per-clock tier", led_code(), model_code());
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int lat;
      // R10: reset state
      rst = 1'b1; warn = '0;
      cycles(4);
      chk(led_code() == 4'b1000, "R10 reset shows green only", led_code(), 4'b1000);
      rst = 1'b0;
      cmp_on = 1'b1;

      // R9: single-cycle pulse stays Safe
      warn = 3'b001;
      cycles(1);
      warn = '0;
      for (int i = 0; i < 30; i++) begin
         cycles(1);
         chk(g === 1'b1, "R9 one-cycle pulse keeps green", g, 1);
      end

      // R1 R5: latency from flag to Caution
      warn = 3'b001;
      lat = 0;
      while (y !== 1'b1 && lat < 200) begin
         cycles(1);
         lat++;
      end
      chk(lat >= 3 + (CTH - 1) * DIV && lat <= 2 + CTH * DIV,
          "R1 R5 caution latency lower/upper bound", lat, 2 + CTH * DIV);
      chk(r === 1'b0, "R2 caution is not red yet", r, 0);

      // R2 R3 R7: reach ceiling and hold
      cycles(60 * DIV);
      chk(r === 1'b1 && bz === 1'b1, "R7 unsafe drives red and buzzer", {r, bz}, 3);
      chk(g === 1'b0 && y === 1'b0, "R7 unsafe has green and yellow off", {g, y}, 0);

      // R3 R4: release from ceiling, red lasts (SMAX-UTH) ticks
      warn = '0;
      cycles((SMAX - UTH) * DIV);
      chk(r === 1'b1, "R3 score saturated at ceiling, still red", r, 1);
      cycles(3 + (SMAX - CTH + 1) * DIV - (SMAX - UTH) * DIV);
      chk(g === 1'b1, "R4 decay returns to green", g, 1);

      // R3: floor does not wrap
      cycles(100);
      chk(g === 1'b1, "R3 long idle stays green, no wrap at zero", g, 1);
      warn = 3'b010;
      cycles((CTH - 1) * DIV);
      chk(g === 1'b1, "R3 climb from floor starts at zero", g, 1);
      warn = '0;
      cycles(60);

      // R8: critical flag held, others random
      for (int i = 0; i < (UTH + 2) * DIV + 3; i++) begin
         warn = {1'b1, 2'($urandom)};
         cycles(1);
      end
      for (int i = 0; i < 50; i++) begin
         chk(r === 1'b1, "R8 critical held keeps red", r, 1);
         warn = 3'(1 << CRIT) | 3'($urandom & 3);
         cycles(1);
      end
      warn = '0;

      // R2 R4 R6 R7: random bursts checked by the model
      for (int i = 0; i < 2000; i++) begin
         if ($urandom % 8 == 0) warn = 3'($urandom);
         if (i % 16 == 0 && ($urandom % 4) != 0) warn = '0;
         cycles(1);
      end

      // R10: reset in mid-run
      warn = 3'b111;
      cycles(40 * DIV);
      rst = 1'b1;
      cycles(1);
      rst = 1'b0;
      chk(led_code() == 4'b1000, "R10 mid-run reset returns to green", led_code(), 4'b1000);
      warn = '0;
      cycles(20);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule